// File: doc/BRIEF.md
# Page-Table Address Translation Unit

This block turns a 14-bit virtual address into a 12-bit physical address by consulting a single-level page table that lives in an external memory. A requester presents a virtual address with an access kind (read, write or execute). The unit adds the upper eight address bits, the virtual page number, to a table base register that selects the current process's table. It fetches that 16-bit table entry over a simple memory read port, checks the entry, and answers with either a physical address or a fault code.

Pages are 64 bytes, so the low six address bits are the in-page offset and pass through unchanged. The entry's six-bit frame number is placed above that offset. A cleared present flag yields a page fault. A set present flag with the permission for the requested access kind missing yields a permission fault. Only one translation is in flight at a time. The unit holds no entry between requests, so when a fault handler rewrites an entry and the access is issued again, the new entry takes effect.

Top module: `pt_xlate`

## Requirements
- R1: On a successful translation, resp_paddr[5:0] equals the request's vaddr[5:0] and resp_paddr[11:6] equals entry bits [5:0].
- R2: The entry address driven on mem_req_addr equals the table base plus vaddr[13:6], zero-extended to 16 bits. mem_req_valid stays high with a stable address until mem_req_ready is seen.
- R3: The table base resets to 0 and is loaded from base_wdata in any cycle with base_we high. Requests accepted after the load use the new base.
- R4: Entry bit 15 is the present flag. When it is 0, the response carries fault code 1 (page fault) and resp_paddr 0, whatever the permission bits hold.
- R5: Entry bits 14, 13 and 12 grant read, write and execute. Access codes are 0 read, 1 write, 2 execute and 3 reserved. A present entry whose bit for the requested kind is 0, or any request with code 3, gives fault code 2 (permission fault) and resp_paddr 0. Code 0 means no fault. Code 3 is never produced.
- R6: req_ready is low from the cycle after a request is accepted until the response cycle. resp_valid is high for exactly one cycle per accepted request, and mem_req_valid is never high while req_ready is high.
- R7: A request repeated after its entry has been rewritten in memory is translated from the rewritten entry. A former fault then completes as a hit.
- R8: After reset, req_ready is 1 and resp_valid and mem_req_valid are 0.
- R9: Entry bits 11:6 are reserved and do not change the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | 16 | New table base (entry-word address) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 14 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 12 | Physical address, 0 on fault |
| resp_fault | output | 2 | 0 none, 1 page fault, 2 permission fault |
| mem_req_valid | output | 1 | Entry fetch request |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_addr | output | 16 | Entry word address |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 16 | Table entry |

## Verification
A corrupted latched offset or access kind shows in the very response of the transaction that latched it, as wrong low address bits or a wrong fault code. A corrupted base or page number shows one fetch earlier, as a wrong mem_req_addr at the handshake. A sequencer left in a wrong state shows as a missing or repeated resp_valid, or as req_ready rising while a fetch is still pending. That is caught within the bounded wait of the same transaction. Random entries, access kinds and table bases, together with directed rewrites of an entry, make each of these visible within one request.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_PAGE = 2'd1,
    FLT_PERM = 2'd2
  } fault_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2
  } xl_state_e;

endpackage

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int MEM_AW = 16,
  parameter int VPN_W  = 8
) (
  input  logic [MEM_AW-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [MEM_AW-1:0] addr
);
  localparam int PAD_W = MEM_AW - VPN_W;

  always_comb addr = base + {{PAD_W{1'b0}}, vpn};
endmodule

// File: rtl/pt_perm_check.sv
module pt_perm_check
  import pt_xlate_pkg::*;
#(
  parameter int PTE_W     = 16,
  parameter int VALID_BIT = 15,
  parameter int PERM_LSB  = 12
) (
  input  logic             present,
  input  logic [2:0]       rwx,
  input  logic [1:0]       acc,
  output fault_e           fault
);
  logic allowed;

  always_comb begin
    case (acc)
      ACC_READ:  allowed = rwx[2];
      ACC_WRITE: allowed = rwx[1];
      ACC_EXEC:  allowed = rwx[0];
      default:   allowed = 1'b0;
    endcase
    if (!present)      fault = FLT_PAGE;
    else if (!allowed) fault = FLT_PERM;
    else               fault = FLT_NONE;
  end
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_xlate_pkg::*;
#(
  parameter int VA_W      = 14,
  parameter int PA_W      = 12,
  parameter int OFF_W     = 6,
  parameter int MEM_AW    = 16,
  parameter int PTE_W     = 16,
  parameter int VALID_BIT = 15,
  parameter int PERM_LSB  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [MEM_AW-1:0] base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  output logic              resp_valid,
  output logic [PA_W-1:0]   resp_paddr,
  output logic [1:0]        resp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  xl_state_e         state;
  logic [MEM_AW-1:0] base_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        acc_q;
  logic [MEM_AW-1:0] ent_addr;
  fault_e            chk_fault;

  pt_entry_addr #(.MEM_AW(MEM_AW), .VPN_W(VPN_W)) u_addr (
    .base (base_q),
    .vpn  (req_vaddr[VA_W-1:OFF_W]),
    .addr (ent_addr)
  );

  pt_perm_check #(.PTE_W(PTE_W), .VALID_BIT(VALID_BIT), .PERM_LSB(PERM_LSB)) u_chk (
    .present (mem_rsp_data[VALID_BIT]),
    .rwx     (mem_rsp_data[PERM_LSB+2:PERM_LSB]),
    .acc     (acc_q),
    .fault   (chk_fault)
  );

  assign req_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      base_q        <= '0;
      off_q         <= '0;
      acc_q         <= ACC_READ;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      resp_valid    <= 1'b0;
      resp_paddr    <= '0;
      resp_fault    <= FLT_NONE;
    end else begin
      resp_valid <= 1'b0;
      if (base_we) base_q <= base_wdata;
      case (state)
        ST_IDLE: if (req_valid) begin
          off_q         <= req_vaddr[OFF_W-1:0];
          acc_q         <= req_acc;
          mem_req_addr  <= ent_addr;
          mem_req_valid <= 1'b1;
          state         <= ST_FETCH;
        end
        ST_FETCH: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          state         <= ST_WAIT;
        end
        ST_WAIT: if (mem_rsp_valid) begin
          resp_valid <= 1'b1;
          resp_fault <= chk_fault;
          resp_paddr <= (chk_fault == FLT_NONE) ?
                        {mem_rsp_data[PPN_W-1:0], off_q} : '0;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)) // R2
    else $error("fetch request dropped");

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready) // R6
    else $error("fetch while idle");

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
    resp_valid |=> !resp_valid) // R6
    else $error("response longer than one cycle");

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_fault == FLT_NONE |-> resp_paddr[OFF_W-1:0] == off_q) // R1
    else $error("offset altered");

  AST_NO_CODE3: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> resp_fault != 2'd3) // R5
    else $error("reserved fault code");

  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (rst)
    resp_valid && resp_fault != FLT_NONE |-> resp_paddr == '0) // R4
    else $error("address on fault");
endmodule

// File: tb/pt_xlate_tb.sv
module pt_xlate_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic base_we = 1'b0;
  logic [15:0] base_wdata = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [13:0] req_vaddr = '0;
  logic [1:0] req_acc = '0;
  logic resp_valid;
  logic [11:0] resp_paddr;
  logic [1:0] resp_fault;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  logic [15:0] mem [1024];
  logic [15:0] last_addr;
  logic [15:0] cur_base = '0;

  always #10 clk = ~clk;

  pt_xlate dut_i (.*);

  // memory model: random ready and response latency
  initial begin
    bit pend = 0;
    int dly = 0;
    logic [15:0] a = '0;
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem[a[9:0]];
          pend = 0;
        end else dly--;
      end else if (mem_req_valid && ($urandom % 3 != 0)) begin
        mem_req_ready = 1'b1;
        a = mem_req_addr;
        last_addr = mem_req_addr;
        pend = 1;
        dly = int'($urandom % 4);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_fault(logic [15:0] pte, logic [1:0] acc);
    if (!pte[15]) return 2'd1;
    if (acc == 2'd3) return 2'd2;
    if (!pte[14 - acc]) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [11:0] exp_pa(logic [15:0] pte, logic [1:0] acc, logic [13:0] va);
    if (exp_fault(pte, acc) != 2'd0) return 12'd0;
    return {pte[5:0], va[5:0]};
  endfunction

  task automatic set_base(logic [15:0] b);
    @(negedge clk);
    base_we = 1'b1;
    base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
    cur_base = b;
  endtask

  task automatic xlate(logic [13:0] va, logic [1:0] acc, string tag);
    logic [15:0] pte;
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R6 busy"}, req_ready, 1'b0);
    while (!resp_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    pte = mem[(cur_base + {8'd0, va[13:6]}) & 16'h3FF];
    chk({tag, " R6 resp"}, resp_valid, 1'b1);
    chk({tag, " R2 addr"}, last_addr, cur_base + {8'd0, va[13:6]});
    chk({tag, " R4 R5 fault"}, resp_fault, exp_fault(pte, acc));
    chk({tag, " R1 paddr"}, resp_paddr, exp_pa(pte, acc, va));
    @(negedge clk);
    chk({tag, " R6 pulse"}, resp_valid, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 1024; i++) mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R8 ready", req_ready, 1'b1);
    chk("R8 resp", resp_valid, 1'b0);
    chk("R8 fetch", mem_req_valid, 1'b0);

    // directed: base 0, table entries at vpn 5..9
    mem[5] = 16'hC02A;            // present, read only, ppn 2A
    xlate(14'h0155, 2'd0, "R1 read hit");
    xlate(14'h0155, 2'd1, "R5 write denied");
    mem[6] = 16'h7005;            // not present, all perms
    xlate(14'h01BF, 2'd0, "R4 page fault priority");
    mem[7] = 16'h9FC7;            // present, exec only, reserved bits set (R9)
    xlate(14'h01C3, 2'd2, "R9 exec hit reserved bits");
    xlate(14'h01C3, 2'd3, "R5 reserved access");
    mem[8] = 16'h0011;
    xlate(14'h0200, 2'd1, "R7 before rewrite");
    mem[8] = 16'hA031;            // rewritten by handler: present, writable
    xlate(14'h0200, 2'd1, "R7 reissue hit");

    // R3: switch base
    mem[256 + 5] = 16'hF03F;
    set_base(16'd256);
    xlate(14'h0155, 2'd1, "R3 new base");

    // random mix
    for (int i = 0; i < 300; i++) begin
      if (i % 25 == 0) set_base(16'(($urandom % 4) * 256));
      xlate(14'($urandom), 2'($urandom), "R1 R5 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule